// File: doc/BRIEF.md
# Rail Over-Current Guard

This block supervises one buck-converter rail of a power-management chip. It watches an over-current comparator flag and reacts only while the chip is in its transceive mode. In clock mode the converters run in forced pulse-frequency mode and limit their own current, so the guard leaves the rail alone there.

When a qualified over-current event arrives in transceive mode, the guard switches the converter off at once. It enables a parallel backup LDO to carry the output and latches a sticky over-current status bit. The backup LDO reports whether it holds regulation. If that flag stays low for a programmable number of cycles (about 20 µs in silicon), the rail is shut down completely.

Once tripped, the rail never returns to the converter by itself. The host re-arms it with a one-cycle strobe from the serial port. If the fault is still present after the re-arm, the rail trips again. Leaving transceive mode also returns the rail to normal operation.

Top module: `rail_fault_guard`

## Requirements
- R1: After reset the outputs are conv_en=1, ldo_en=0, rail_off=0 and oc_status=0.
- R2: While mode_trx=0 (clock mode), oc_flag has no effect: conv_en stays 1, ldo_en and rail_off stay 0, and oc_status does not change.
- R3: oc_flag counts as a fault only when it is sampled high on FILT_LEN (default 2) consecutive rising edges. A single-cycle pulse causes no trip. When the flag has been high for two edges, the trip takes effect on the next edge.
- R4: A qualified fault in transceive mode, with the rail in normal operation, does all of the following on the same edge: conv_en falls to 0, ldo_en rises to 1 and oc_status is set to 1.
- R5: During backup, if ldo_good is sampled low on HOLD_CYCLES consecutive edges, the rail shuts down on the last of those edges: conv_en=0, ldo_en=0, rail_off=1.
- R6: During backup, any edge that samples ldo_good high restarts the shutdown count from zero.
- R7: During backup with ldo_good high and oc_flag cleared, the guard stays in backup indefinitely and never sets conv_en to 1 without a re-arm.
- R8: A host_rearm strobe sampled in transceive mode during backup or shutdown returns the outputs to conv_en=1, ldo_en=0, rail_off=0 on that edge, and clears oc_status.
- R9: If the fault is still qualified when the rail is re-armed, the rail trips again on the next edge and oc_status is set again.
- R10: Sampling mode_trx=0 returns the outputs to normal operation on that edge, from any state.
- R11: oc_status is sticky: only host_rearm (in any mode) or reset clears it. A new fault that is detected on the same edge as a strobe takes priority, so the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_trx | input | 1 | 1 = transceive mode, 0 = clock mode |
| oc_flag | input | 1 | Over-current comparator flag, active high |
| ldo_good | input | 1 | Backup LDO in-regulation flag |
| host_rearm | input | 1 | One-cycle re-arm strobe from the serial port |
| conv_en | output | 1 | Buck converter enable |
| ldo_en | output | 1 | Backup LDO enable |
| rail_off | output | 1 | Rail shut down |
| oc_status | output | 1 | Sticky over-current status bit |

## Verification
The embedded properties assume that every input is synchronous to clk, and that host_rearm is a strobe, not a level held across a trip. Otherwise a held strobe would keep clearing the status bit and could bounce the state between normal and backup.

The bench changes every input only on the falling clock edge and pulses host_rearm for exactly one cycle. It holds oc_flag low for at least two cycles before a strobe whenever it expects a clean re-arm. The timer property assumes that ldo_good only matters while the rail is in backup, and the stimulus exercises it only from that state.

// File: rtl/rail_fault_guard_pkg.sv
package rail_fault_guard_pkg;

  typedef enum logic [1:0] {
    RG_NORMAL   = 2'd0,
    RG_BACKUP   = 2'd1,
    RG_SHUTDOWN = 2'd2
  } rg_state_e;

  typedef struct packed {
    logic conv_en;
    logic ldo_en;
    logic rail_off;
  } rg_drive_t;

endpackage

// File: rtl/rg_oc_filter.sv
module rg_oc_filter #(
  parameter int FILT_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_in,
  output logic oc_qual
);

  logic [FILT_LEN-1:0] hist_q;

  generate
    if (FILT_LEN == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= oc_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {hist_q[FILT_LEN-2:0], oc_in};
      end
    end
  endgenerate

  assign oc_qual = &hist_q;

  AST_QUAL_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    oc_qual |-> $past(oc_in)); // R3

endmodule

// File: rtl/rg_hold_timer.sv
module rg_hold_timer #(
  parameter int HOLD_CYCLES = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ldo_good,
  output logic expire
);

  localparam int CW = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign expire = run && !ldo_good && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (!run || ldo_good || expire) cnt_q <= '0;
    else                              cnt_q <= cnt_q + CW'(1);
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R5
  AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ldo_good |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/rg_ctrl.sv
module rg_ctrl
  import rail_fault_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      mode_trx,
  input  logic      oc_qual,
  input  logic      expire,
  input  logic      host_rearm,
  output logic      in_backup,
  output rg_drive_t drive,
  output logic      oc_status
);

  rg_state_e state_q, state_d;
  logic      set_evt;

  assign set_evt = mode_trx && (state_q == RG_NORMAL) && oc_qual;

  always_comb begin
    state_d = state_q;
    if (!mode_trx) begin
      state_d = RG_NORMAL;
    end else begin
      unique case (state_q)
        RG_NORMAL:   if (oc_qual) state_d = RG_BACKUP;
        RG_BACKUP:   if (host_rearm) state_d = RG_NORMAL;
                     else if (expire) state_d = RG_SHUTDOWN;
        RG_SHUTDOWN: if (host_rearm) state_d = RG_NORMAL;
        default:     state_d = RG_NORMAL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RG_NORMAL;
      oc_status <= 1'b0;
    end else begin
      state_q <= state_d;
      if (set_evt)         oc_status <= 1'b1;
      else if (host_rearm) oc_status <= 1'b0;
    end
  end

  assign in_backup = (state_q == RG_BACKUP) && mode_trx;

  always_comb begin
    unique case (state_q)
      RG_BACKUP:   drive = '{conv_en: 1'b0, ldo_en: 1'b1, rail_off: 1'b0};
      RG_SHUTDOWN: drive = '{conv_en: 1'b0, ldo_en: 1'b0, rail_off: 1'b1};
      default:     drive = '{conv_en: 1'b1, ldo_en: 1'b0, rail_off: 1'b0};
    endcase
  end

  AST_CLOCK_MODE_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_trx |=> drive.conv_en && !drive.ldo_en && !drive.rail_off); // R10
  AST_TRIP_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_trx && drive.conv_en && oc_qual) |=> (drive.ldo_en && oc_status)); // R4
  AST_SHUTDOWN_FROM_BACKUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive.rail_off) |-> $past(drive.ldo_en)); // R5
  AST_NO_SELF_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_trx && !drive.conv_en && !host_rearm) |=> !drive.conv_en); // R7
  AST_REARM_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_trx && !drive.conv_en && host_rearm) |=> (drive.conv_en && !oc_status)); // R8
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_status && !host_rearm) |=> oc_status); // R11

endmodule

// File: rtl/rail_fault_guard.sv
module rail_fault_guard
  import rail_fault_guard_pkg::*;
#(
  parameter int FILT_LEN    = 2,
  parameter int HOLD_CYCLES = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_trx,
  input  logic oc_flag,
  input  logic ldo_good,
  input  logic host_rearm,
  output logic conv_en,
  output logic ldo_en,
  output logic rail_off,
  output logic oc_status
);

  logic      oc_qual;
  logic      expire;
  logic      in_backup;
  rg_drive_t drive;

  rg_oc_filter #(.FILT_LEN(FILT_LEN)) u_filter (
    .clk     (clk),
    .rst_n   (rst_n),
    .oc_in   (oc_flag),
    .oc_qual (oc_qual)
  );

  rg_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (in_backup),
    .ldo_good (ldo_good),
    .expire   (expire)
  );

  rg_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_trx   (mode_trx),
    .oc_qual    (oc_qual),
    .expire     (expire),
    .host_rearm (host_rearm),
    .in_backup  (in_backup),
    .drive      (drive),
    .oc_status  (oc_status)
  );

  assign conv_en  = drive.conv_en;
  assign ldo_en   = drive.ldo_en;
  assign rail_off = drive.rail_off;

  AST_CLOCK_IGNORES_OC: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_trx && conv_en) |=> conv_en); // R2

endmodule

// File: tb/rail_fault_guard_tb_top.sv
module rail_fault_guard_tb_top;

  localparam int HOLD = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_trx = 1'b0;
  logic oc_flag = 1'b0;
  logic ldo_good = 1'b1;
  logic host_rearm = 1'b0;
  logic conv_en, ldo_en, rail_off, oc_status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rail_fault_guard #(.FILT_LEN(2), .HOLD_CYCLES(HOLD)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_trx   (mode_trx),
    .oc_flag    (oc_flag),
    .ldo_good   (ldo_good),
    .host_rearm (host_rearm),
    .conv_en    (conv_en),
    .ldo_en     (ldo_en),
    .rail_off   (rail_off),
    .oc_status  (oc_status)
  );

  // {conv_en, ldo_en, rail_off, oc_status}
  localparam logic [3:0] NORM0 = 4'b1000;
  localparam logic [3:0] NORM1 = 4'b1001;
  localparam logic [3:0] BKUP  = 4'b0101;
  localparam logic [3:0] SHUT  = 4'b0011;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {conv_en, ldo_en, rail_off, oc_status};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_rearm();
    host_rearm = 1'b1;
    tick(1);
    host_rearm = 1'b0;
  endtask

  task automatic go_normal();
    mode_trx = 1'b1; oc_flag = 1'b0; ldo_good = 1'b1;
    tick(3);
    pulse_rearm();
    tick(1);
  endtask

  task automatic trip(input logic good);
    ldo_good = good;
    oc_flag = 1'b1;
    tick(3);
  endtask

  task automatic t_reset();
    check("R1", NORM0);
  endtask

  task automatic t_clock_ignore();
    mode_trx = 1'b0; oc_flag = 1'b1; ldo_good = 1'b0;
    tick(10);
    check("R2", NORM0);
    oc_flag = 1'b0; ldo_good = 1'b1;
    tick(3);
  endtask

  task automatic t_glitch();
    go_normal();
    oc_flag = 1'b1; tick(1);
    oc_flag = 1'b0; tick(5);
    check("R3", NORM0);
    oc_flag = 1'b1; tick(2);
    check("R3", NORM0);
    tick(1);
    check("R3", BKUP);
    check("R4", BKUP);
  endtask

  task automatic t_timeout();
    go_normal();
    trip(1'b0);
    check("R4", BKUP);
    oc_flag = 1'b0;
    tick(HOLD - 1);
    check("R5", BKUP);
    tick(1);
    check("R5", SHUT);
    tick(5);
    check("R8", SHUT);
  endtask

  task automatic t_restart();
    go_normal();
    trip(1'b0);
    oc_flag = 1'b0;
    tick(HOLD - 5);
    ldo_good = 1'b1; tick(1);
    ldo_good = 1'b0; tick(HOLD - 1);
    check("R6", BKUP);
    tick(1);
    check("R6", SHUT);
  endtask

  task automatic t_hold_backup();
    go_normal();
    trip(1'b1);
    oc_flag = 1'b0;
    tick(HOLD * 3);
    check("R7", BKUP);
  endtask

  task automatic t_rearm();
    // from backup
    go_normal();
    trip(1'b1);
    oc_flag = 1'b0; tick(3);
    pulse_rearm();
    check("R8", NORM0);
    // from shutdown
    trip(1'b0);
    oc_flag = 1'b0;
    tick(HOLD + 2);
    check("R5", SHUT);
    ldo_good = 1'b1;
    pulse_rearm();
    check("R8", NORM0);
  endtask

  task automatic t_persist();
    go_normal();
    trip(1'b0);
    tick(HOLD);
    check("R9", SHUT);
    pulse_rearm();
    check("R9", NORM0);
    tick(1);
    check("R9", BKUP);
    tick(HOLD);
    check("R9", SHUT);
    oc_flag = 1'b0;
  endtask

  task automatic t_simultaneous();
    go_normal();
    oc_flag = 1'b1; tick(2);
    host_rearm = 1'b1; tick(1); host_rearm = 1'b0;
    check("R11", BKUP);
    oc_flag = 1'b0;
  endtask

  task automatic t_leave_trx();
    go_normal();
    trip(1'b1);
    oc_flag = 1'b0;
    mode_trx = 1'b0; tick(1);
    check("R10", NORM1);
    tick(10);
    check("R11", NORM1);
    pulse_rearm();
    check("R11", NORM0);
    go_normal();
    trip(1'b0);
    tick(HOLD);
    oc_flag = 1'b0;
    mode_trx = 1'b0; tick(1);
    check("R10", NORM1);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_clock_ignore();
    t_glitch();
    t_timeout();
    t_restart();
    t_hold_backup();
    t_rearm();
    t_persist();
    t_simultaneous();
    t_leave_trx();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule